// File: doc/BRIEF.md
# Address-Signature Memory Preloader

This controller prepares an embedded RAM so that the RAM behaves as a transparent path from its address pins to its data pins. It sweeps an address counter over every location. Into each word it writes that word's own address, or the part of the address selected for the current pass. After the sweep it asserts a read-hold output that keeps the RAM's control at a constant read. With the hold in place, the normal test stimulus can exercise the address logic and can change nothing stored in the RAM.

When the RAM word is narrower than the address, a full check takes several passes. Pass `p` stores address bits `[p*WORD_W +: WORD_W]`. Address bits beyond the top of the address read as zero, so the last slice may carry zeros in its high bits. When the word is wider than the address, the spare high bits are written as zero. Software or a test sequencer picks a pass, pulses `start`, and waits for `done`.

The RAM write port is a valid/ready stream. `wr_valid` is high only while the sweep is running. A write takes place in each cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the offered address and data stay unchanged, so the RAM side may stall for any number of cycles.

Top module: `memsig_preloader`

## Requirements
- R1: After reset, `wr_valid`, `done` and `read_hold` are low and `cur_pass` is 0.
- R2: When `start` is sampled high with a legal `pass_sel` and no sweep is running (idle or holding), then in the next cycle `read_hold` and `done` are low, `wr_valid` is high, `wr_addr` is 0 and `cur_pass` equals the requested pass.
- R3: In each sweep every address from 0 to 2^ADDR_W-1 is written exactly once, in ascending order, and the address advances only on a cycle where `wr_valid` and `wr_ready` are both high.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` keep their values into the next cycle and `wr_valid` stays high.
- R5: The word written in pass p at address a is bits [p*WORD_W +: WORD_W] of a. Address bits beyond ADDR_W-1 count as zero, and this includes the padding bits of a word wider than the address.
- R6: The number of passes is ceil(ADDR_W/WORD_W). A `start` whose `pass_sel` is that number or higher is ignored: no sweep begins, and `read_hold` and `cur_pass` are unchanged.
- R7: In the cycle after the write of the last address, `wr_valid` is low and `done` and `read_hold` are high. `done` lasts one cycle. `read_hold` stays high until the next accepted start.
- R8: A `start` that arrives while a sweep is running is ignored. The sweep completes with its original pass and writes each address once.
- R9: `read_hold` and `wr_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a sweep for `pass_sel` |
| pass_sel | input | PASS_W | Address slice to load |
| wr_valid | output | 1 | Write offered to the RAM |
| wr_ready | input | 1 | RAM accepts the offered write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | WORD_W | Write data (address slice) |
| read_hold | output | 1 | Holds the RAM control at read |
| done | output | 1 | One-cycle pulse when a sweep completes |
| cur_pass | output | PASS_W | Slice currently loaded or being loaded |

## Verification
The bench builds two instances. The first uses a 5-bit address with 2-bit words. That gives three passes, and the last slice has only one real address bit, so zero fill in the top slice can be observed, and the pass index 3 exists as an out-of-range value. The second uses a 5-bit address with 8-bit words. That gives a single pass with three padding bits. The narrow instance is run under several stall patterns on `wr_ready`, which exercises the stream hold rule of R4 and the ordering of R3.

// File: rtl/preload_pkg.sv
package preload_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2
  } pl_state_e;

  function automatic int calc_passes(int aw, int ww);
    return (aw + ww - 1) / ww;
  endfunction

  function automatic int calc_pass_w(int np);
    return (np > 1) ? $clog2(np) : 1;
  endfunction

endpackage

// File: rtl/addr_cycler.sv
module addr_cycler #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (clear) begin
      addr <= '0;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  assign at_last = (addr == LAST_ADDR);

endmodule

// File: rtl/slice_select.sv
module slice_select #(
  parameter int ADDR_W   = 6,
  parameter int WORD_W   = 4,
  parameter int NUM_PASS = 2,
  parameter int PASS_W   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PASS_W-1:0] pass,
  output logic [WORD_W-1:0] data
);

  localparam int EXT_W = NUM_PASS * WORD_W;

  logic [EXT_W-1:0]  ext;
  logic [WORD_W-1:0] slices [NUM_PASS];

  // zero-extend the address to a whole number of words
  assign ext = EXT_W'(addr);

  for (genvar g = 0; g < NUM_PASS; g++) begin : g_slice
    assign slices[g] = ext[g*WORD_W +: WORD_W];
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_PASS; i++) begin
      if (pass == PASS_W'(i)) data = slices[i];
    end
  end

endmodule

// File: rtl/preload_fsm.sv
module preload_fsm
  import preload_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pass_ok,
  input  logic wr_fire,
  input  logic at_last,
  output logic accept,
  output logic filling,
  output logic holding,
  output logic done
);

  pl_state_e state;

  assign filling = (state == ST_FILL);
  assign holding = (state == ST_HOLD);
  assign accept  = !filling && start && pass_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE, ST_HOLD: if (accept) state <= ST_FILL;
        ST_FILL: begin
          if (wr_fire && at_last) begin
            state <= ST_HOLD;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/memsig_preloader.sv
module memsig_preloader
  import preload_pkg::*;
#(
  parameter  int ADDR_W   = 6,
  parameter  int WORD_W   = 4,
  localparam int NUM_PASS = calc_passes(ADDR_W, WORD_W),
  localparam int PASS_W   = calc_pass_w(NUM_PASS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PASS_W-1:0] pass_sel,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              read_hold,
  output logic              done,
  output logic [PASS_W-1:0] cur_pass
);

  logic pass_ok;
  logic accept;
  logic wr_fire;
  logic at_last;

  assign pass_ok = ({1'b0, pass_sel} < (PASS_W + 1)'(NUM_PASS));
  assign wr_fire = wr_valid && wr_ready;

  preload_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .pass_ok (pass_ok),
    .wr_fire (wr_fire),
    .at_last (at_last),
    .accept  (accept),
    .filling (wr_valid),
    .holding (read_hold),
    .done    (done)
  );

  addr_cycler #(.ADDR_W(ADDR_W)) u_cycler (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .step    (wr_fire),
    .addr    (wr_addr),
    .at_last (at_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cur_pass <= '0;
    else if (accept) cur_pass <= pass_sel;
  end

  slice_select #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .NUM_PASS (NUM_PASS),
    .PASS_W   (PASS_W)
  ) u_slice (
    .addr (wr_addr),
    .pass (cur_pass),
    .data (wr_data)
  );

endmodule

// File: rtl/memsig_preloader_chk.sv
module memsig_preloader_chk
  import preload_pkg::*;
#(
  parameter  int ADDR_W   = 6,
  parameter  int WORD_W   = 4,
  localparam int NUM_PASS = calc_passes(ADDR_W, WORD_W),
  localparam int PASS_W   = calc_pass_w(NUM_PASS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [PASS_W-1:0] pass_sel,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              read_hold,
  input logic              done,
  input logic [PASS_W-1:0] cur_pass
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic legal;
  assign legal = ({1'b0, pass_sel} < (PASS_W + 1)'(NUM_PASS));

  AST_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(read_hold && wr_valid)); // R9

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R4

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start && legal && !wr_valid |=> wr_valid && wr_addr == '0 && !read_hold && !done
      && cur_pass == $past(pass_sel)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_addr != TOP |=> wr_valid && wr_addr == $past(wr_addr) + 1'b1); // R3

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_addr == TOP |=> !wr_valid && done && read_hold); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_PASS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> $stable(cur_pass)); // R8

  AST_BAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !legal && !wr_valid |=> !wr_valid && $stable(cur_pass) && $stable(read_hold)); // R6

  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cur_pass} < (PASS_W + 1)'(NUM_PASS))); // R6

endmodule

bind memsig_preloader memsig_preloader_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_memsig_preloader.sv
`timescale 1ns/1ps
module test_memsig_preloader;

  localparam int AW  = 5;
  localparam int NW  = 2;   // narrow word: 3 passes
  localparam int WW  = 8;   // wide word: 1 pass
  localparam int NA  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // narrow instance
  logic          start = 1'b0;
  logic [1:0]    pass_sel = '0;
  logic          wr_valid, wr_ready, read_hold, done;
  logic [AW-1:0] wr_addr;
  logic [NW-1:0] wr_data;
  logic [1:0]    cur_pass;

  memsig_preloader #(.ADDR_W(AW), .WORD_W(NW)) i_memsig_preloader (
    .clk(clk), .rst_n(rst_n), .start(start), .pass_sel(pass_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .read_hold(read_hold), .done(done), .cur_pass(cur_pass));

  // wide instance
  logic          start_w = 1'b0;
  logic          pass_w = 1'b0;
  logic          valid_w, hold_w, done_w;
  logic [AW-1:0] addr_w;
  logic [WW-1:0] data_w;
  logic          cpass_w;

  memsig_preloader #(.ADDR_W(AW), .WORD_W(WW)) i_wide (
    .clk(clk), .rst_n(rst_n), .start(start_w), .pass_sel(pass_w),
    .wr_valid(valid_w), .wr_ready(1'b1), .wr_addr(addr_w), .wr_data(data_w),
    .read_hold(hold_w), .done(done_w), .cur_pass(cpass_w));

  int checks = 0;
  int errors = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern: 0 always ready, 1 low every third cycle, 2 alternating
  int stall_mode = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    case (stall_mode)
      1:       wr_ready <= (cyc % 3) != 0;
      2:       wr_ready <= cyc[0];
      default: wr_ready <= 1'b1;
    endcase
  end

  // RAM models and stream monitors
  logic [NW-1:0] shadow   [NA];
  logic [WW-1:0] shadow_w [NA];
  int wr_count = 0, order_err = 0, stall_err = 0, excl_err = 0, wcount_w = 0;
  int exp_addr = 0;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [NW-1:0] prev_data;

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!wr_valid || wr_addr != prev_addr || wr_data != prev_data)) stall_err++;
      if (read_hold && wr_valid) excl_err++;
      if (wr_valid && wr_ready) begin
        if (int'(wr_addr) != exp_addr) order_err++;
        shadow[wr_addr] = wr_data;
        wr_count++;
        exp_addr++;
      end
      if (valid_w) begin
        shadow_w[addr_w] = data_w;
        wcount_w++;
      end
      prev_stall = wr_valid && !wr_ready;
      prev_addr  = wr_addr;
      prev_data  = wr_data;
    end
  end

  task automatic clear_model();
    for (int a = 0; a < NA; a++) shadow[a] = '1 ^ NW'(a);
    wr_count = 0; exp_addr = 0; order_err = 0;
  endtask

  task automatic check_contents(string req, int p);
    int bad = 0;
    for (int a = 0; a < NA; a++)
      if (shadow[a] !== NW'((a >> (p * NW)) & ((1 << NW) - 1))) bad++;
    check(req, bad, 0);
  endtask

  // run one sweep; poke > 0 pulses a second start mid-sweep
  task automatic run_pass(int p, int mode, int poke);
    int n = 0;
    stall_mode = mode;
    clear_model();
    @(negedge clk); start = 1'b1; pass_sel = 2'(p);
    @(negedge clk); start = 1'b0;
    check("R2 valid after start", wr_valid, 1);
    check("R2 hold released", read_hold, 0);
    check("R2 addr zero", wr_addr, 0);
    check("R2 pass loaded", cur_pass, p);
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke > 0 && n == poke) begin
        start = 1'b1; pass_sel = 2'((p + 1) % 3);
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check("R7 done seen", done, 1);
    check("R7 hold with done", read_hold, 1);
    check("R7 valid low", wr_valid, 0);
    check("R3 write count", wr_count, NA);
    check("R3 ascending order", order_err, 0);
    check("R8 pass kept", cur_pass, p);
    check_contents("R5 slice contents", p);
    @(negedge clk);
    check("R7 done is a pulse", done, 0);
    check("R7 hold persists", read_hold, 1);
  endtask

  // {pass, stall mode, poke cycle}
  localparam logic [11:0] VEC [6] = '{
    {2'd0, 2'd0, 8'd0},
    {2'd1, 2'd1, 8'd0},
    {2'd2, 2'd2, 8'd0},
    {2'd0, 2'd1, 8'd0},
    {2'd1, 2'd2, 8'd7},
    {2'd2, 2'd0, 8'd3}
  };

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", wr_valid, 0);
    check("R1 done", done, 0);
    check("R1 hold", read_hold, 0);
    check("R1 pass", cur_pass, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 out-of-range pass from idle
    start = 1'b1; pass_sel = 2'd3;
    @(negedge clk); start = 1'b0;
    check("R6 bad pass idle no sweep", wr_valid, 0);
    check("R6 bad pass idle hold", read_hold, 0);

    foreach (VEC[i]) run_pass(int'(VEC[i][11:10]), int'(VEC[i][9:8]), int'(VEC[i][7:0]));

    // R6 out-of-range pass while holding
    @(negedge clk); start = 1'b1; pass_sel = 2'd3;
    @(negedge clk); start = 1'b0;
    check("R6 bad pass hold no sweep", wr_valid, 0);
    check("R6 bad pass hold kept", read_hold, 1);
    check("R6 bad pass cur_pass", cur_pass, 2);

    stall_mode = 0;
    check("R4 stall stability", stall_err, 0);
    check("R9 hold/valid exclusive", excl_err, 0);

    // wide word: address plus zero padding
    @(negedge clk); start_w = 1'b1; pass_w = 1'b1;
    @(negedge clk); start_w = 1'b0;
    check("R6 wide bad pass", valid_w, 0);
    start_w = 1'b1; pass_w = 1'b0;
    @(negedge clk); start_w = 1'b0;
    check("R2 wide start", valid_w, 1);
    repeat (NA) @(negedge clk);
    check("R7 wide done", done_w, 1);
    check("R7 wide hold", hold_w, 1);
    check("R3 wide count", wcount_w, NA);
    begin
      int bad = 0;
      for (int a = 0; a < NA; a++) if (shadow_w[a] !== WW'(a)) bad++;
      check("R5 wide padding", bad, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule